// File: doc/BRIEF.md
# Core-Only Firmware Update Reset Sequencer

This block lets running software restart only the embedded processor core so that a new firmware image can be loaded without disturbing anything else. A single write to a trigger register on a simple register bus starts a sequence. The sequence drives an active-low core reset. One cycle later it clears the instruction-memory lock. It keeps the reset low for a programmable hold count, then releases it synchronously through a two-stage synchronizer. Bus targets, their registers and the local memories are outside the reset domain this block drives, so they keep running and keep their contents.

Software first sets the instruction-memory lock through the lock register while firmware runs. It then programs the hold count, if the default does not suit, and writes the trigger. It can poll the busy status bit to see when the core has come back out of reset and the boot path has started reloading the instruction memory. The global power-on reset overrides every part of the sequence.

Top module: `fwrst_seq_top`

## Requirements
- R1: While power-on reset `rst_n` is low, the outputs are as follows: `core_rst_n_o`=0, `busy_o`=0, `imem_lock_o`=0, and the hold register reads 5. After `rst_n` rises, `core_rst_n_o` is still 0 after the first clock edge and is 1 after the second.
- R2: If a write to address 0 has bit 0 set while the block is idle, the sequence starts at that edge (edge 0). `core_rst_n_o` goes low after edge 1, stays low for exactly H+1 cycles, and is high again after edge H+2, where H is the effective hold count.
- R3: The hold count register at address 1 holds a HOLD_W-bit value, reset value 5, and reads back what was written. A stored value of 0 acts as a hold of 1. A new value takes effect at the next trigger.
- R4: `lock_clr_o` is high for exactly one cycle, the one after the first cycle with `core_rst_n_o` low (after edge 2), and the core reset is still asserted during it.
- R5: Bit 0 of address 2 is the instruction-memory lock, also driven on `imem_lock_o`. Writing 1 sets it and writing 0 has no effect. Only the `lock_clr_o` pulse clears it, at the end of the pulse cycle, or power-on reset does.
- R6: `busy_o`, which also reads as bit 0 of address 3, is high from edge 0 until edge H+2, the edge at which `core_rst_n_o` returns high.
- R7: A trigger write made while `busy_o` is high is ignored. The reset timing of the running sequence does not change and no second sequence follows it.
- R8: Reads of address 0 return 0, because the trigger bit clears itself. Reads of unmapped addresses also return 0.
- R9: Power-on reset asserted in the middle of a sequence forces `core_rst_n_o` low, `busy_o` low, the lock to 0 and the hold count to 5 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| core_rst_n_o | output | 1 | Active-low reset to the processor core only |
| imem_lock_o | output | 1 | Instruction-memory lock state |
| lock_clr_o | output | 1 | One-cycle lock-clear pulse |
| busy_o | output | 1 | Sequence in progress |

## Verification
The assertions assume that `reg_we`, `reg_addr` and `reg_wdata` are stable around each rising edge and that one write is presented per cycle. They also assume that `rst_n` is released away from an active edge, so the synchronizer and hold counter start from their reset values. The stimulus changes every bus input and `rst_n` only on falling clock edges and samples all outputs there too. Retrigger attempts land in both the hold phase and the release phase, and power-on reset is applied in the middle of a hold.

// File: rtl/fwrst_pkg.sv
package fwrst_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_HOLD = 2'd1,
    SQ_REL  = 2'd2
  } seq_state_e;

  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_HOLD = 1;
  localparam int unsigned REG_LOCK = 2;
  localparam int unsigned REG_STAT = 3;
endpackage

// File: rtl/fwrst_regfile.sv
module fwrst_regfile #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned HOLD_W   = 8,
  parameter int unsigned HOLD_DEF = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              lock_clr,
  output logic [DATA_W-1:0] rdata,
  output logic              trig,
  output logic [HOLD_W-1:0] hold_q,
  output logic              lock_q
);
  import fwrst_pkg::*;

  localparam logic [HOLD_W-1:0] HOLD_RST = HOLD_W'(HOLD_DEF);

  logic              sel_ctrl, sel_hold, sel_lock, sel_stat;
  logic              hold_en, lock_en;
  logic [HOLD_W-1:0] hold_d;
  logic              lock_d;

  assign sel_ctrl = (addr == ADDR_W'(REG_CTRL));
  assign sel_hold = (addr == ADDR_W'(REG_HOLD));
  assign sel_lock = (addr == ADDR_W'(REG_LOCK));
  assign sel_stat = (addr == ADDR_W'(REG_STAT));

  assign trig = we && sel_ctrl && wdata[0];

  always_comb begin
    hold_en = we && sel_hold;
    hold_d  = wdata[HOLD_W-1:0];
    lock_en = lock_clr || (we && sel_lock && wdata[0]);
    lock_d  = !lock_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= HOLD_RST;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_hold) begin
      rdata[HOLD_W-1:0] = hold_q;
    end else if (sel_lock) begin
      rdata[0] = lock_q;
    end else if (sel_stat) begin
      rdata[0] = busy;
    end
  end

  // R5
  lock_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(we && sel_lock && wdata[0]));

  // R5
  lock_drop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> $past(lock_clr));
endmodule

// File: rtl/fwrst_ctl.sv
module fwrst_ctl #(
  parameter int unsigned HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [HOLD_W-1:0] hold_val,
  input  logic              sync_first,
  output logic              rst_req,
  output logic              busy
);
  import fwrst_pkg::*;

  localparam logic [HOLD_W-1:0] ONE = HOLD_W'(1);

  seq_state_e        state_q, state_d;
  logic [HOLD_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;
  logic [HOLD_W-1:0] hold_eff;

  assign hold_eff = (hold_val == '0) ? ONE : hold_val;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (trig) begin
          state_d = SQ_HOLD;
          cnt_d   = hold_eff;
          cnt_en  = 1'b1;
        end
      end
      SQ_HOLD: begin
        cnt_en = 1'b1;
        if (cnt_q == ONE) begin
          state_d = SQ_REL;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      SQ_REL: begin
        if (sync_first) begin
          state_d = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign rst_req = (state_q == SQ_HOLD);
  assign busy    = (state_q != SQ_IDLE);

  // R3
  hold_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_HOLD) |-> (cnt_q != '0));

  // R7
  retrig_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_REL && trig) |=> (state_q != SQ_HOLD));

  // R7
  retrig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_HOLD && trig && cnt_q != ONE) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/fwrst_sync2.sv
module fwrst_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic first,
  output logic out_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else if (req) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign first = s1_q;
  assign out_n = s2_q;

  // R2
  rel_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_n) |-> ($past(first) && !$past(req)));
endmodule

// File: rtl/fwrst_lockpulse.sv
module fwrst_lockpulse (
  input  logic clk,
  input  logic rst_n,
  input  logic core_rst_n,
  output logic pulse
);
  logic prev_q, pulse_q, pulse_d;

  assign pulse_d = prev_q && !core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= core_rst_n;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

  // R4
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/fwrst_seq_top.sv
module fwrst_seq_top #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned HOLD_W   = 8,
  parameter int unsigned HOLD_DEF = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              core_rst_n_o,
  output logic              imem_lock_o,
  output logic              lock_clr_o,
  output logic              busy_o
);
  logic              trig;
  logic [HOLD_W-1:0] hold_q;
  logic              rst_req;
  logic              sync_first;

  fwrst_regfile #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .HOLD_W  (HOLD_W),
    .HOLD_DEF(HOLD_DEF)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .busy    (busy_o),
    .lock_clr(lock_clr_o),
    .rdata   (reg_rdata),
    .trig    (trig),
    .hold_q  (hold_q),
    .lock_q  (imem_lock_o)
  );

  fwrst_ctl #(
    .HOLD_W(HOLD_W)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .hold_val  (hold_q),
    .sync_first(sync_first),
    .rst_req   (rst_req),
    .busy      (busy_o)
  );

  fwrst_sync2 u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (rst_req),
    .first(sync_first),
    .out_n(core_rst_n_o)
  );

  fwrst_lockpulse u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .core_rst_n(core_rst_n_o),
    .pulse     (lock_clr_o)
  );

  // R4
  clr_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_clr_o |-> !core_rst_n_o);

  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> core_rst_n_o);

  // R2
  core_low_when_busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |=> !core_rst_n_o);
endmodule

// File: tb/sim_fwrst_seq_top.sv
module sim_fwrst_seq_top;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;
  localparam int NV = 6;
  localparam int VEC_HOLD [NV] = '{0, 1, 5, 3, 12, 2};
  localparam int VEC_EFF  [NV] = '{1, 1, 5, 3, 12, 2};

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_we;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] reg_wdata;
  logic [DATA_W-1:0] reg_rdata;
  logic              core_rst_n_o, imem_lock_o, lock_clr_o, busy_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fwrst_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_rst_n_o(core_rst_n_o),
    .imem_lock_o(imem_lock_o), .lock_clr_o(lock_clr_o), .busy_o(busy_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = DATA_W'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = ADDR_W'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic run_seq(input int retrig, output int first_low, output int lows,
                         output int clr_idx, output int clr_cnt, output int busy_end);
    first_low = -1; lows = 0; clr_idx = -1; clr_cnt = 0; busy_end = -1;
    wr(0, 1);
    for (int i = 1; i < 40; i++) begin
      if (i == retrig) begin
        reg_we = 1'b1; reg_addr = '0; reg_wdata = 1;
      end
      @(negedge clk);
      reg_we = 1'b0;
      if (!core_rst_n_o) begin
        lows++;
        if (first_low < 0) first_low = i;
      end
      if (lock_clr_o) begin
        clr_cnt++;
        clr_idx = i;
      end
      if (!busy_o && busy_end < 0) busy_end = i;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int d, fl, lw, ci, cc, be;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 core_rst_n in reset", int'(core_rst_n_o), 0);
    chk("R1 busy in reset", int'(busy_o), 0);
    chk("R1 lock in reset", int'(imem_lock_o), 0);
    reg_addr = 1; #1 chk("R1 hold default", int'(reg_rdata), 5);
    rst_n = 1'b1;
    @(negedge clk); chk("R1 core low after 1st edge", int'(core_rst_n_o), 0);
    @(negedge clk); chk("R1 core high after 2nd edge", int'(core_rst_n_o), 1);

    // R2 R3 R4 R5 R6 vector table
    for (int v = 0; v < NV; v++) begin
      wr(1, VEC_HOLD[v]);
      rd(1, d); chk("R3 hold readback", d, VEC_HOLD[v]);
      wr(2, 1);
      rd(2, d); chk("R5 lock set", d, 1);
      run_seq(-1, fl, lw, ci, cc, be);
      chk("R2 first low edge", fl, 1);
      chk("R2 R3 low cycles", lw, VEC_EFF[v] + 1);
      chk("R4 lock_clr cycle", ci, 2);
      chk("R4 lock_clr count", cc, 1);
      chk("R6 busy end edge", be, VEC_EFF[v] + 2);
      rd(2, d); chk("R5 lock cleared", d, 0);
      chk("R5 imem_lock_o cleared", int'(imem_lock_o), 0);
    end

    // R5 writing 0 has no effect
    wr(2, 1); wr(2, 0);
    rd(2, d); chk("R5 write 0 ignored", d, 1);

    // R8 trigger readback and unmapped
    rd(0, d); chk("R8 ctrl reads 0", d, 0);
    rd(7, d); chk("R8 unmapped reads 0", d, 0);
    rd(3, d); chk("R6 status idle", d, 0);

    // R7 retrigger during hold and during release
    wr(1, 3);
    run_seq(2, fl, lw, ci, cc, be);
    chk("R7 hold retrig low cycles", lw, 4);
    chk("R7 hold retrig busy end", be, 5);
    run_seq(4, fl, lw, ci, cc, be);
    chk("R7 rel retrig low cycles", lw, 4);
    chk("R7 rel retrig busy end", be, 5);
    chk("R7 rel retrig single clr", cc, 1);

    // R6 status bit during sequence, R8 ctrl read while busy
    wr(0, 1);
    reg_addr = 3; #1 chk("R6 status busy", int'(reg_rdata), 1);
    reg_addr = 0; #1 chk("R8 ctrl reads 0 while busy", int'(reg_rdata), 0);
    repeat (10) @(negedge clk);

    // R9 power-on reset mid-sequence
    wr(1, 10);
    wr(2, 1);
    wr(0, 1);
    @(negedge clk);
    chk("R9 core low before por", int'(core_rst_n_o), 0);
    rst_n = 1'b0;
    #1;
    chk("R9 core low in por", int'(core_rst_n_o), 0);
    chk("R9 busy cleared", int'(busy_o), 0);
    chk("R9 lock cleared", int'(imem_lock_o), 0);
    reg_addr = 1; #1 chk("R9 hold reset", int'(reg_rdata), 5);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); chk("R9 core low 1 edge after release", int'(core_rst_n_o), 0);
    @(negedge clk); chk("R9 core high 2 edges after release", int'(core_rst_n_o), 1);
    chk("R9 busy idle after release", int'(busy_o), 0);

    finish_run();
  end
endmodule